// File: doc/BRIEF.md
# Writeback Load/Store Micro-op Cracker

This block sits after instruction decode and turns one memory macro-op that also updates its base register into a short, ordered run of micro-ops. A descriptor arrives on a valid/ready handshake. It names the access kind, the offset mode, the add/subtract direction, up to two destination registers, the base and index registers, a shift amount and type, and an immediate. The block then emits one micro-op per accepted output cycle. Each micro-op carries an opcode, its register fields and a flag that marks the final step.

The block picks a two-step form (access, then base update) when nothing conflicts. It picks a three-step form when a load would overwrite the index register before the base update reads it, or when a load writes the program counter. In both three-step forms a temporary register carries the value across the steps, and in the PC case the PC write comes last. Macro-ops without writeback pass through as a single micro-op.

Top module: `wb_uop_cracker`

## Requirements
- R1: With writeback clear, exactly one micro-op is emitted: opcode MEM (0) carrying every descriptor field unchanged (rd=dst0, rd2=dst1, rn=base, rm=idx, shift, imm, kind), with last set.
- R2: With writeback set and no conflict, two micro-ops are emitted: first MEM as in R1 with last clear, then the base update with rd=rn=base, rd2=0, rm=idx, shift and imm copied, last set.
- R3: The base-update opcode is ADDI (1) or SUBI (2) for immediate offset, and ADDR (3) or SUBR (4) for register offset. The add flag selects the add form.
- R4: A single load (kind 0) or dual load (kind 2) with register offset, writeback and dst0 equal to idx emits three micro-ops: MOV (5) with rd=TMP, rn=idx; then MEM; then the base update with rm=TMP. A MOV carries zero in rd2, rm, shift and imm. With immediate offset the R2 form is used.
- R5: A single load with writeback and dst0 equal to the PC index emits MEM with rd=TMP, then the base update, then MOV rd=PC, rn=TMP as the final step. This takes priority over R4.
- R6: A dual load with register offset and writeback uses the R4 sequence when either dst0 or dst1 equals idx.
- R7: Stores (kind 1 single, kind 3 dual) with writeback always use the two-step form, whatever their register fields hold.
- R8: Return-from-exception (kind 4) and save-state (kind 5) accesses with writeback emit MEM and then ADDI with the immediate. The add flag and the offset mode have no effect on them.
- R9: Only the final micro-op carries last. The conditional-advance output pulses in exactly the cycle when a micro-op with last set is accepted downstream.
- R10: in_ready is low from the cycle after a descriptor is accepted until the cycle after the final micro-op is accepted. While out_valid is high and out_ready is low, the outputs hold steady.
- R11: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_kind | input | 3 | 0 load, 1 store, 2 dual load, 3 dual store, 4 return-from-exception, 5 save-state |
| in_wb | input | 1 | Base register is updated |
| in_regofs | input | 1 | 1 = shifted-register offset, 0 = immediate |
| in_add | input | 1 | 1 = add offset, 0 = subtract |
| in_dst0 | input | 5 | First destination/data register |
| in_dst1 | input | 5 | Second destination/data register |
| in_base | input | 5 | Base register |
| in_idx | input | 5 | Index register |
| in_shamt | input | 5 | Index shift amount |
| in_shtype | input | 2 | Index shift type |
| in_imm | input | 12 | Immediate offset |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Downstream accepts the micro-op |
| out_op | output | 3 | 0 MEM, 1 ADDI, 2 SUBI, 3 ADDR, 4 SUBR, 5 MOV |
| out_kind | output | 3 | Kind of the parent macro-op |
| out_rd | output | 5 | Destination register |
| out_rd2 | output | 5 | Second destination register |
| out_rn | output | 5 | First source (base or move source) |
| out_rm | output | 5 | Index source |
| out_shamt | output | 5 | Shift amount |
| out_shtype | output | 2 | Shift type |
| out_imm | output | 12 | Immediate |
| out_last | output | 1 | Final micro-op of the sequence |
| out_cond_adv | output | 1 | Pulse: final micro-op accepted |

## Verification
The hardest situation to reach is a three-step sequence held up in its middle step. The block must keep both the rerouted temporary register and the PC-last ordering while downstream refuses micro-ops and a new descriptor already waits at the input. The stimulus reaches it by driving directed PC-destination and index-conflict loads first with out_ready always high and then with out_ready withheld on a pseudo-random pattern. A stream of random descriptors follows, with registers drawn from a small pool that includes the PC, so that conflicts and overlaps of the PC and index checks come up often. Each accepted micro-op is compared with a queue filled by an independent model.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned IMM_W   = 12;
  localparam int unsigned SHA_W   = 5;
  localparam int unsigned SHT_W   = 2;
  localparam int unsigned SEQ_MAX = 3;
  localparam int unsigned STEP_W  = $clog2(SEQ_MAX);

  typedef enum logic [2:0] {
    K_LOAD = 3'd0, K_STORE = 3'd1, K_LOAD2 = 3'd2,
    K_STORE2 = 3'd3, K_RETEXC = 3'd4, K_SAVEST = 3'd5
  } mkind_e;

  typedef enum logic [2:0] {
    U_MEM = 3'd0, U_ADDI = 3'd1, U_SUBI = 3'd2,
    U_ADDR = 3'd3, U_SUBR = 3'd4, U_MOV = 3'd5
  } uop_e;

  typedef enum logic [1:0] {SH_ONE, SH_TWO, SH_COPY, SH_PC} shape_e;

  typedef struct packed {
    mkind_e             kind;
    logic               wb;
    logic               regofs;
    logic               add;
    logic [REG_W-1:0]   dst0;
    logic [REG_W-1:0]   dst1;
    logic [REG_W-1:0]   base;
    logic [REG_W-1:0]   idx;
    logic [SHA_W-1:0]   shamt;
    logic [SHT_W-1:0]   shtype;
    logic [IMM_W-1:0]   imm;
  } macro_t;

  typedef struct packed {
    uop_e               op;
    mkind_e             kind;
    logic [REG_W-1:0]   rd;
    logic [REG_W-1:0]   rd2;
    logic [REG_W-1:0]   rn;
    logic [REG_W-1:0]   rm;
    logic [SHA_W-1:0]   shamt;
    logic [SHT_W-1:0]   shtype;
    logic [IMM_W-1:0]   imm;
    logic               last;
  } uop_t;

  // Base-update opcode from offset mode and direction.
  function automatic uop_e update_op(input mkind_e kind, input logic regofs,
                                     input logic add);
    if (kind == K_RETEXC || kind == K_SAVEST) return U_ADDI;
    if (regofs) return add ? U_ADDR : U_SUBR;
    return add ? U_ADDI : U_SUBI;
  endfunction

  // Sequence shape; the PC check is tested before the index conflict.
  function automatic shape_e choose_shape(input macro_t m,
                                          input logic [REG_W-1:0] pc_r);
    logic ld1, ld2, hit;
    ld1 = (m.kind == K_LOAD);
    ld2 = (m.kind == K_LOAD2);
    hit = m.regofs && ((m.dst0 == m.idx) || (ld2 && (m.dst1 == m.idx)));
    if (!m.wb) return SH_ONE;
    if (ld1 && (m.dst0 == pc_r)) return SH_PC;
    if ((ld1 || ld2) && hit) return SH_COPY;
    return SH_TWO;
  endfunction
endpackage

// File: rtl/wbc_planner.sv
module wbc_planner
  import wbc_pkg::*;
#(
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned TMP_IDX = 16
) (
  input  macro_t mac,
  output uop_t   plan [SEQ_MAX]
);
  localparam logic [REG_W-1:0] PC_R  = PC_IDX[REG_W-1:0];
  localparam logic [REG_W-1:0] TMP_R = TMP_IDX[REG_W-1:0];

  shape_e shape;
  uop_t   acc_u, upd_u, mov_in_u, mov_pc_u;

  function automatic uop_t make_mov(input mkind_e k, input logic [REG_W-1:0] dst,
                                    input logic [REG_W-1:0] src);
    uop_t u;
    u      = '0;
    u.op   = U_MOV;
    u.kind = k;
    u.rd   = dst;
    u.rn   = src;
    return u;
  endfunction

  always_comb begin
    shape = choose_shape(mac, PC_R);

    acc_u        = '0;
    acc_u.op     = U_MEM;
    acc_u.kind   = mac.kind;
    acc_u.rd     = mac.dst0;
    acc_u.rd2    = mac.dst1;
    acc_u.rn     = mac.base;
    acc_u.rm     = mac.idx;
    acc_u.shamt  = mac.shamt;
    acc_u.shtype = mac.shtype;
    acc_u.imm    = mac.imm;

    upd_u        = '0;
    upd_u.op     = update_op(mac.kind, mac.regofs, mac.add);
    upd_u.kind   = mac.kind;
    upd_u.rd     = mac.base;
    upd_u.rn     = mac.base;
    upd_u.rm     = mac.idx;
    upd_u.shamt  = mac.shamt;
    upd_u.shtype = mac.shtype;
    upd_u.imm    = mac.imm;

    mov_in_u = make_mov(mac.kind, TMP_R, mac.idx);
    mov_pc_u = make_mov(mac.kind, PC_R, TMP_R);

    for (int i = 0; i < SEQ_MAX; i++) plan[i] = '0;

    unique case (shape)
      SH_ONE: begin
        plan[0]      = acc_u;
        plan[0].last = 1'b1;
      end
      SH_TWO: begin
        plan[0]      = acc_u;
        plan[1]      = upd_u;
        plan[1].last = 1'b1;
      end
      SH_COPY: begin
        plan[0]      = mov_in_u;
        plan[1]      = acc_u;
        plan[2]      = upd_u;
        plan[2].rm   = TMP_R;
        plan[2].last = 1'b1;
      end
      default: begin
        plan[0]      = acc_u;
        plan[0].rd   = TMP_R;
        plan[1]      = upd_u;
        plan[2]      = mov_pc_u;
        plan[2].last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/wbc_sequencer.sv
module wbc_sequencer
  import wbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  uop_t plan [SEQ_MAX],
  input  logic out_ready,
  output logic busy,
  output uop_t cur,
  output logic fire_last
);
  uop_t              slots [SEQ_MAX];
  logic [STEP_W-1:0] step;
  logic              hs;

  assign cur       = slots[step];
  assign hs        = busy && out_ready;
  assign fire_last = hs && cur.last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      for (int i = 0; i < SEQ_MAX; i++) slots[i] <= '0;
    end else if (!busy) begin
      if (take) begin
        busy  <= 1'b1;
        step  <= '0;
        slots <= plan;
      end
    end else if (fire_last) begin
      busy <= 1'b0;
      step <= '0;
    end else if (hs) begin
      step <= step + 1'b1;
    end
  end

  // R10: a stalled micro-op stays put until accepted
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(cur)));

  // R9: accepting a non-final step keeps the sequence going
  a_r9_not_last_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !cur.last) |=> busy);
endmodule

// File: rtl/wb_uop_cracker.sv
module wb_uop_cracker
  import wbc_pkg::*;
#(
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned TMP_IDX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_kind,
  input  logic             in_wb,
  input  logic             in_regofs,
  input  logic             in_add,
  input  logic [4:0]       in_dst0,
  input  logic [4:0]       in_dst1,
  input  logic [4:0]       in_base,
  input  logic [4:0]       in_idx,
  input  logic [4:0]       in_shamt,
  input  logic [1:0]       in_shtype,
  input  logic [11:0]      in_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_op,
  output logic [2:0]       out_kind,
  output logic [4:0]       out_rd,
  output logic [4:0]       out_rd2,
  output logic [4:0]       out_rn,
  output logic [4:0]       out_rm,
  output logic [4:0]       out_shamt,
  output logic [1:0]       out_shtype,
  output logic [11:0]      out_imm,
  output logic             out_last,
  output logic             out_cond_adv
);
  localparam logic [REG_W-1:0] PC_R  = PC_IDX[REG_W-1:0];
  localparam logic [REG_W-1:0] TMP_R = TMP_IDX[REG_W-1:0];

  macro_t mac;
  uop_t   plan [SEQ_MAX];
  uop_t   cur;
  logic   busy, take, fire_last;

  always_comb begin
    mac.kind   = mkind_e'(in_kind);
    mac.wb     = in_wb;
    mac.regofs = in_regofs;
    mac.add    = in_add;
    mac.dst0   = in_dst0;
    mac.dst1   = in_dst1;
    mac.base   = in_base;
    mac.idx    = in_idx;
    mac.shamt  = in_shamt;
    mac.shtype = in_shtype;
    mac.imm    = in_imm;
  end

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  wbc_planner #(.PC_IDX(PC_IDX), .TMP_IDX(TMP_IDX)) planner_i (
    .mac  (mac),
    .plan (plan)
  );

  wbc_sequencer seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .plan      (plan),
    .out_ready (out_ready),
    .busy      (busy),
    .cur       (cur),
    .fire_last (fire_last)
  );

  assign out_valid    = busy;
  assign out_op       = cur.op;
  assign out_kind     = cur.kind;
  assign out_rd       = cur.rd;
  assign out_rd2      = cur.rd2;
  assign out_rn       = cur.rn;
  assign out_rm       = cur.rm;
  assign out_shamt    = cur.shamt;
  assign out_shtype   = cur.shtype;
  assign out_imm      = cur.imm;
  assign out_last     = cur.last;
  assign out_cond_adv = fire_last;

  // R5: a micro-op writing the PC from a single load closes its sequence
  a_r5_pc_write_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rd == PC_R &&
     (cur.op == U_MOV || (cur.op == U_MEM && cur.kind == K_LOAD))) |-> out_last);

  // R4: a sequence opens with the access or the temporary copy of the index
  a_r4_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (cur.op == U_MEM || (cur.op == U_MOV && out_rd == TMP_R)));

  // R10: the input is released in the cycle after the final acceptance
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);
endmodule

// File: tb/wb_uop_cracker_tb_top.sv
module wb_uop_cracker_tb_top;
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  kind;
    logic [4:0]  rd, rd2, rn, rm, shamt;
    logic [1:0]  shtype;
    logic [11:0] imm;
    logic        last;
    logic [7:0]  req;
  } exp_t;

  localparam logic [4:0] PC  = 5'd15;
  localparam logic [4:0] TMP = 5'd16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_kind = '0;
  logic in_wb = 1'b0, in_regofs = 1'b0, in_add = 1'b0;
  logic [4:0] in_dst0 = '0, in_dst1 = '0, in_base = '0, in_idx = '0, in_shamt = '0;
  logic [1:0] in_shtype = '0;
  logic [11:0] in_imm = '0;
  logic out_valid, out_ready = 1'b1;
  logic [2:0] out_op, out_kind;
  logic [4:0] out_rd, out_rd2, out_rn, out_rm, out_shamt;
  logic [1:0] out_shtype;
  logic [11:0] out_imm;
  logic out_last, out_cond_adv;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  logic ready_mode = 1'b0;
  logic mon_on = 1'b0;

  always #10 clk = ~clk;

  wb_uop_cracker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_wb(in_wb), .in_regofs(in_regofs), .in_add(in_add),
    .in_dst0(in_dst0), .in_dst1(in_dst1), .in_base(in_base), .in_idx(in_idx),
    .in_shamt(in_shamt), .in_shtype(in_shtype), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_kind(out_kind), .out_rd(out_rd), .out_rd2(out_rd2), .out_rn(out_rn),
    .out_rm(out_rm), .out_shamt(out_shamt), .out_shtype(out_shtype),
    .out_imm(out_imm), .out_last(out_last), .out_cond_adv(out_cond_adv)
  );

  function automatic exp_t mk(logic [2:0] op, logic [2:0] k, logic [4:0] rd,
      logic [4:0] rd2, logic [4:0] rn, logic [4:0] rm, logic [4:0] sa,
      logic [1:0] st, logic [11:0] im, logic lst, int req);
    exp_t e;
    e = '{op: op, kind: k, rd: rd, rd2: rd2, rn: rn, rm: rm, shamt: sa,
          shtype: st, imm: im, last: lst, req: req[7:0]};
    return e;
  endfunction

  task automatic note_fail(int req, string what, longint act, longint exp);
    n_bad++;
    $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // Driver: expectations from the requirement text, then the handshake.
  task automatic send(logic [2:0] k, logic wb, logic ro, logic ad,
      logic [4:0] d0, logic [4:0] d1, logic [4:0] b, logic [4:0] ix,
      logic [4:0] sa, logic [1:0] st, logic [11:0] im, int req);
    logic is_ld, pc_dst, clash;
    logic [2:0] uop;
    logic [4:0] mem_rd, upd_rm;
    is_ld  = (k == 3'd0) || (k == 3'd2);
    pc_dst = (k == 3'd0) && (d0 == PC);
    clash  = ro && ((d0 == ix) || ((k == 3'd2) && (d1 == ix)));
    if (k >= 3'd4) uop = 3'd1;                 // R8: always ADDI
    else if (ro)   uop = ad ? 3'd3 : 3'd4;     // R3 register forms
    else           uop = ad ? 3'd1 : 3'd2;     // R3 immediate forms
    mem_rd = (wb && pc_dst) ? TMP : d0;
    upd_rm = (is_ld && !pc_dst && clash) ? TMP : ix;
    if (!wb) begin                                          // R1
      q.push_back(mk(3'd0, k, d0, d1, b, ix, sa, st, im, 1'b1, req));
    end else if (is_ld && pc_dst) begin                     // R5
      q.push_back(mk(3'd0, k, mem_rd, d1, b, ix, sa, st, im, 1'b0, req));
      q.push_back(mk(uop, k, b, 5'd0, b, upd_rm, sa, st, im, 1'b0, req));
      q.push_back(mk(3'd5, k, PC, 5'd0, TMP, 5'd0, 5'd0, 2'd0, 12'd0, 1'b1, req));
    end else if (is_ld && clash) begin                      // R4, R6
      q.push_back(mk(3'd5, k, TMP, 5'd0, ix, 5'd0, 5'd0, 2'd0, 12'd0, 1'b0, req));
      q.push_back(mk(3'd0, k, d0, d1, b, ix, sa, st, im, 1'b0, req));
      q.push_back(mk(uop, k, b, 5'd0, b, upd_rm, sa, st, im, 1'b1, req));
    end else begin                                          // R2, R7, R8
      q.push_back(mk(3'd0, k, d0, d1, b, ix, sa, st, im, 1'b0, req));
      q.push_back(mk(uop, k, b, 5'd0, b, upd_rm, sa, st, im, 1'b1, req));
    end
    in_kind = k; in_wb = wb; in_regofs = ro; in_add = ad;
    in_dst0 = d0; in_dst1 = d1; in_base = b; in_idx = ix;
    in_shamt = sa; in_shtype = st; in_imm = im;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #2 in_valid = 1'b0;
  endtask

  // out_ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #2 out_ready <= ready_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor: samples at the falling edge
  logic stalled = 1'b0;
  logic want_ready = 1'b0;
  logic [63:0] held;
  always @(negedge clk) begin
    if (mon_on) begin
      if (want_ready) begin
        n_cmp++;
        if (!in_ready) note_fail(10, "in_ready after final step", in_ready, 1);
        want_ready = 1'b0;
      end
      if (out_valid && in_ready) begin
        n_cmp++;
        note_fail(10, "in_ready while busy", in_ready, 0);
      end
      if (stalled && out_valid) begin
        n_cmp++;
        if ({out_op, out_rd, out_rd2, out_rn, out_rm, out_imm, out_last} != held[44:0])
          note_fail(10, "stalled output moved",
                    {out_op, out_rd, out_rd2, out_rn, out_rm, out_imm, out_last}, held[44:0]);
      end
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        held = {19'd0, out_op, out_rd, out_rd2, out_rn, out_rm, out_imm, out_last};
        if (out_cond_adv) begin
          n_cmp++;
          note_fail(9, "advance pulse while stalled", out_cond_adv, 0);
        end
      end
      if (out_valid && out_ready) begin
        exp_t e, a;
        n_cmp++;
        if (q.size() == 0) begin
          note_fail(9, "unexpected micro-op", out_op, 7);
        end else begin
          e = q.pop_front();
          a = mk(out_op, out_kind, out_rd, out_rd2, out_rn, out_rm, out_shamt,
                 out_shtype, out_imm, out_last, int'(e.req));
          if (a != e) note_fail(int'(e.req), "micro-op", a, e);
          if (out_cond_adv != e.last)
            note_fail(9, "advance pulse", out_cond_adv, e.last);
        end
        if (out_last) want_ready = 1'b1;
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    note_fail(10, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic directed();
    // R1: no writeback, single step
    send(3'd0, 1'b0, 1'b1, 1'b1, 5'd3, 5'd9, 5'd4, 5'd5, 5'd2, 2'd1, 12'h011, 1);
    send(3'd1, 1'b0, 1'b0, 1'b0, PC, 5'd1, 5'd2, 5'd2, 5'd0, 2'd0, 12'h7ff, 1);
    send(3'd0, 1'b0, 1'b0, 1'b1, PC, 5'd0, 5'd6, 5'd6, 5'd0, 2'd0, 12'h004, 1);
    // R2, R3: plain two-step, each update opcode
    send(3'd0, 1'b1, 1'b0, 1'b1, 5'd2, 5'd0, 5'd6, 5'd7, 5'd0, 2'd0, 12'h010, 2);
    send(3'd0, 1'b1, 1'b0, 1'b0, 5'd2, 5'd0, 5'd6, 5'd7, 5'd0, 2'd0, 12'h020, 3);
    send(3'd0, 1'b1, 1'b1, 1'b1, 5'd1, 5'd0, 5'd6, 5'd7, 5'd2, 2'd1, 12'h000, 3);
    send(3'd0, 1'b1, 1'b1, 1'b0, 5'd1, 5'd0, 5'd6, 5'd7, 5'd31, 2'd3, 12'h000, 3);
    // R4: destination equals index; immediate offset stays two-step
    send(3'd0, 1'b1, 1'b1, 1'b1, 5'd7, 5'd0, 5'd3, 5'd7, 5'd1, 2'd2, 12'h000, 4);
    send(3'd0, 1'b1, 1'b0, 1'b1, 5'd7, 5'd0, 5'd3, 5'd7, 5'd0, 2'd0, 12'h00c, 4);
    // R5: PC destination, and PC over index conflict
    send(3'd0, 1'b1, 1'b0, 1'b1, PC, 5'd0, 5'd13, 5'd0, 5'd0, 2'd0, 12'h008, 5);
    send(3'd0, 1'b1, 1'b1, 1'b0, PC, 5'd0, 5'd13, PC, 5'd3, 2'd0, 12'h000, 5);
    // R6: dual loads
    send(3'd2, 1'b1, 1'b1, 1'b1, 5'd4, 5'd5, 5'd8, 5'd5, 5'd0, 2'd0, 12'h000, 6);
    send(3'd2, 1'b1, 1'b1, 1'b0, 5'd5, 5'd6, 5'd8, 5'd5, 5'd4, 2'd1, 12'h000, 6);
    send(3'd2, 1'b1, 1'b1, 1'b1, 5'd1, 5'd2, 5'd8, 5'd5, 5'd0, 2'd0, 12'h000, 6);
    // R7: stores never take three steps
    send(3'd1, 1'b1, 1'b1, 1'b1, 5'd5, 5'd0, 5'd8, 5'd5, 5'd0, 2'd0, 12'h000, 7);
    send(3'd1, 1'b1, 1'b0, 1'b0, PC, 5'd0, 5'd8, 5'd5, 5'd0, 2'd0, 12'h044, 7);
    send(3'd3, 1'b1, 1'b1, 1'b0, 5'd5, 5'd5, 5'd8, 5'd5, 5'd1, 2'd0, 12'h000, 7);
    // R8: exception return / state save, add flag and mode ignored
    send(3'd4, 1'b1, 1'b1, 1'b0, PC, 5'd0, 5'd13, 5'd13, 5'd0, 2'd0, 12'h008, 8);
    send(3'd5, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 5'd13, 5'd0, 5'd0, 2'd0, 12'hff8, 8);
  endtask

  function automatic logic [4:0] pick_reg();
    int p;
    p = $urandom % 10;
    return (p == 9) ? PC : 5'(p);
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    n_cmp++;
    if (out_valid !== 1'b0) note_fail(11, "out_valid after reset", out_valid, 0);
    n_cmp++;
    if (in_ready !== 1'b1) note_fail(11, "in_ready after reset", in_ready, 1);
    mon_on = 1'b1;
    @(posedge clk); #2;
    directed();
    ready_mode = 1'b1;           // R10: back-pressure on the same set
    directed();
    for (int i = 0; i < 60; i++) begin
      send(3'($urandom % 6), 1'($urandom), 1'($urandom), 1'($urandom),
           pick_reg(), pick_reg(), pick_reg(), pick_reg(),
           5'($urandom), 2'($urandom), 12'($urandom), 2);
    end
    for (int i = 0; i < 200 && q.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    n_cmp++;
    if (q.size() != 0) note_fail(9, "micro-ops never emitted", q.size(), 0);
    finish_run();
  end
endmodule